// File: doc/BRIEF.md
# Halfword-Only Memory Access Bridge

This block sits between a host that issues byte, halfword and word accesses and a 64 KB memory window that accepts only 16-bit transfers. It accepts one host request at a time. It turns the request into zero, one or two halfword transfers on the target port and then returns one response to the host.

Words are big-endian. The more significant half sits at the lower address and is always transferred first. A byte read fetches the halfword that contains the byte. The byte lane is chosen by the parity of the address. Requests the target cannot serve are answered at once with an error flag and cause no target transfer: misaligned accesses, byte writes and low-half word writes.

The host request channel and the response channel are both valid/ready.
- A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the bridge is idle.
- Once `rsp_valid` rises, it stays high with stable data and error flag until a cycle where `rsp_ready` is high. The host may stall the response for any number of cycles.
- The target port is a request/acknowledge pair. `tgt_req` and its address, direction and write data stay still until `tgt_ack` is seen. The acknowledge may arrive any number of cycles later.

Top module: `hw_bridge`

## Requirements
- R1: A word read (`req_size` = 2'b10, address bits [1:0] = 0) issues a halfword read at A, then one at A+2. It returns {data at A, data at A+2}.
- R2: A word write (`req_size` = 2'b10) sends `req_wdata[31:16]` to A first, then `req_wdata[15:0]` to A+2.
- R3: A low-half word read (`req_size` = 2'b11, address bits [1:0] = 0) issues a single halfword read at A+2. It returns that halfword zero-extended to 32 bits.
- R4: A byte read (`req_size` = 2'b00) at even A reads the halfword at A and returns its bits [15:8]. At odd A it reads the halfword at A-1 and returns its bits [7:0]. The result is zero-extended.
- R5: A halfword access (`req_size` = 2'b01, address bit 0 = 0) makes one transfer at A. A write sends `req_wdata[15:0]`. A read returns the halfword zero-extended.
- R6: A halfword request at an odd address, or a word or low-half word request whose address bits [1:0] are not 0, gives `rsp_err` = 1 and `rsp_rdata` = 0, with no target transfer.
- R7: A byte write, or a write with `req_size` = 2'b11, gives `rsp_err` = 1 with no target transfer.
- R8: `tgt_req`, `tgt_addr`, `tgt_we` and `tgt_wdata` stay unchanged until `tgt_ack` is sampled high. Acknowledge delays of zero or more cycles are tolerated.
- R9: `req_ready` is low from acceptance until the response has been taken. `rsp_valid`, `rsp_rdata` and `rsp_err` hold while `rsp_ready` is low.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0 and `tgt_req` = 0. A supported access responds with `rsp_err` = 0, and a write responds with `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 low-half word |
| req_addr | input | ADDR_W | Byte address in the window |
| req_wdata | input | 32 | Write data, right-aligned for halfword |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes response |
| rsp_rdata | output | 32 | Read result, zero-extended |
| rsp_err | output | 1 | Request rejected |
| tgt_req | output | 1 | Halfword transfer request |
| tgt_we | output | 1 | Transfer is a write |
| tgt_addr | output | ADDR_W | Halfword byte address (bit 0 = 0) |
| tgt_wdata | output | 16 | Halfword write data |
| tgt_rdata | input | 16 | Halfword read data, valid with ack |
| tgt_ack | input | 1 | Transfer complete |

## Verification
The bench builds the bridge with the default `ADDR_W` = 16, so the whole 64 KB window is addressable. This puts the top-edge cases within reach: a word at 0xFFFC whose second half sits at 0xFFFE, and a byte read at 0xFFFF. Each random run draws its address over the full window, so misaligned requests fall out of the stimulus naturally. Acknowledge delays of zero to three cycles, together with random response stalls, exercise the holding rules of both handshakes.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WLOW = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic err;
    logic two_phase;
    logic full_word;
    logic is_byte;
    logic byte_odd;
  } plan_t;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output plan_t             plan,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] second_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic misaligned;
  logic bad_write;
  logic [ADDR_W-1:0] even_addr;

  assign even_addr   = {addr[ADDR_W-1:1], 1'b0};
  assign second_addr = addr + STEP;

  always_comb begin
    misaligned = 1'b0;
    bad_write  = 1'b0;
    first_addr = addr;
    unique case (size_e'(size))
      SZ_BYTE: begin
        bad_write  = write;
        first_addr = even_addr;
      end
      SZ_HALF: misaligned = addr[0];
      SZ_WORD: misaligned = |addr[1:0];
      SZ_WLOW: begin
        misaligned = |addr[1:0];
        bad_write  = write;
        first_addr = second_addr;
      end
      default: ;
    endcase
    plan.err       = misaligned | bad_write;
    plan.two_phase = (size_e'(size) == SZ_WORD) & ~plan.err;
    plan.full_word = (size_e'(size) == SZ_WORD);
    plan.is_byte   = (size_e'(size) == SZ_BYTE);
    plan.byte_odd  = addr[0];
  end
endmodule

// File: rtl/hwb_rdpack.sv
module hwb_rdpack
  import hwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [HALF_W-1:0] tgt_rdata,
  input  plan_t             plan,
  input  logic              write,
  output logic [WORD_W-1:0] rdata
);
  logic [HALF_W-1:0] hi_q, lo_q;
  logic [WORD_W-1:0] packed_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cap_hi) hi_q <= tgt_rdata;
      if (cap_lo) lo_q <= tgt_rdata;
    end
  end

  always_comb begin
    if (plan.full_word)
      packed_w = {hi_q, lo_q};
    else if (plan.is_byte)
      packed_w = {24'b0, plan.byte_odd ? lo_q[7:0] : lo_q[15:8]};
    else
      packed_w = {{(WORD_W-HALF_W){1'b0}}, lo_q};
    rdata = (write | plan.err) ? '0 : packed_w;
  end

  AST_NO_DOUBLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hi && cap_lo)) else $error("capture overlap"); // R1
endmodule

// File: rtl/hw_bridge.sv
module hw_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [15:0]       tgt_wdata,
  input  logic [15:0]       tgt_rdata,
  input  logic              tgt_ack
);
  state_e            state_q;
  plan_t             dec_plan, plan_q;
  logic [ADDR_W-1:0] dec_a0, dec_a1, a0_q, a1_q;
  logic [WORD_W-1:0] wdata_q;
  logic              write_q;
  logic              accept;

  hwb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .write      (req_write),
    .size       (req_size),
    .addr       (req_addr),
    .plan       (dec_plan),
    .first_addr (dec_a0),
    .second_addr(dec_a1)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plan_q  <= '0;
      a0_q    <= '0;
      a1_q    <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          plan_q  <= dec_plan;
          a0_q    <= dec_a0;
          a1_q    <= dec_a1;
          wdata_q <= req_wdata;
          write_q <= req_write;
          state_q <= dec_plan.err ? ST_DONE : ST_FIRST;
        end
        ST_FIRST:  if (tgt_ack) state_q <= plan_q.two_phase ? ST_SECOND : ST_DONE;
        ST_SECOND: if (tgt_ack) state_q <= ST_DONE;
        ST_DONE:   if (rsp_ready) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tgt_req   = (state_q == ST_FIRST) | (state_q == ST_SECOND);
    tgt_we    = tgt_req & write_q;
    tgt_addr  = (state_q == ST_SECOND) ? a1_q : a0_q;
    tgt_wdata = (state_q == ST_FIRST && plan_q.two_phase) ? wdata_q[31:16] : wdata_q[15:0];
  end

  hwb_rdpack u_rdpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi   ((state_q == ST_FIRST) & tgt_ack & plan_q.two_phase),
    .cap_lo   (tgt_ack & ((state_q == ST_SECOND) | ((state_q == ST_FIRST) & ~plan_q.two_phase))),
    .tgt_rdata(tgt_rdata),
    .plan     (plan_q),
    .write    (write_q),
    .rdata    (rsp_rdata)
  );

  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_err   = plan_q.err;

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_addr) && $stable(tgt_we) && $stable(tgt_wdata))
    else $error("target request dropped or changed"); // R8
  AST_SECOND_HALF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tgt_ack && state_q == ST_FIRST && plan_q.two_phase
      |=> tgt_req && tgt_addr == ADDR_W'($past(tgt_addr) + ADDR_W'(2)))
    else $error("second half not at A+2"); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))
    else $error("response not held"); // R9
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_plan.err |=> rsp_valid && rsp_err && !tgt_req)
    else $error("rejected request reached target"); // R6
  AST_BYTE_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && req_size == 2'b00 |=> rsp_err && !tgt_req)
    else $error("byte write not rejected"); // R7
endmodule

// File: tb/hw_bridge_test.sv
module hw_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, tgt_req, tgt_we;
  logic [31:0] rsp_rdata;
  logic [15:0] tgt_addr, tgt_wdata;
  logic [15:0] tgt_rdata = '0;
  logic tgt_ack = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int dly = 0;
  int log_n = 0;
  logic [15:0] log_addr [4];
  logic        log_we   [4];
  logic [15:0] log_data [4];

  always #4 clk = ~clk;

  hw_bridge #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack)
  );

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h3C};
  endfunction

  // target model: acknowledges after 0..3 extra cycles, logs each transfer
  always @(negedge clk) begin
    cycles++;
    if (tgt_ack) tgt_ack = 1'b0;
    else if (tgt_req) begin
      if (dly == 0) begin
        tgt_ack   = 1'b1;
        tgt_rdata = mem_val(tgt_addr);
        if (log_n < 4) begin
          log_addr[log_n] = tgt_addr;
          log_we[log_n]   = tgt_we;
          log_data[log_n] = tgt_wdata;
        end
        log_n++;
        dly = $urandom % 4;
      end else dly--;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit wr, input logic [1:0] sz, input logic [15:0] a);
    if (wr && (sz == 2'b00 || sz == 2'b11)) return "R7";
    if ((sz == 2'b01 && a[0]) || (sz[1] && a[1:0] != 2'b00)) return "R6";
    case (sz)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return wr ? "R2" : "R1";
      default: return "R3";
    endcase
  endfunction

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd);
    string tag = tag_of(wr, sz, a);
    bit e_err = (tag == "R6" || tag == "R7");
    int e_n = 0;
    logic [15:0] e_addr [2];
    logic [15:0] e_data [2];
    logic [31:0] e_rd = '0;
    logic [31:0] held;
    int stall;
    if (!e_err) begin
      case (sz)
        2'b00: begin e_n = 1; e_addr[0] = {a[15:1], 1'b0};
                 e_rd = {24'b0, a[0] ? mem_val(e_addr[0])[7:0] : mem_val(e_addr[0])[15:8]}; end
        2'b01: begin e_n = 1; e_addr[0] = a; e_data[0] = wd[15:0]; e_rd = {16'b0, mem_val(a)}; end
        2'b10: begin e_n = 2; e_addr[0] = a; e_addr[1] = a + 16'd2;
                 e_data[0] = wd[31:16]; e_data[1] = wd[15:0];
                 e_rd = {mem_val(a), mem_val(a + 16'd2)}; end
        default: begin e_n = 1; e_addr[0] = a + 16'd2; e_rd = {16'b0, mem_val(a + 16'd2)}; end
      endcase
      if (wr) e_rd = '0;
    end
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R9", "ready while busy", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    stall = $urandom % 3;
    for (int i = 0; i < stall; i++) @(negedge clk);
    check(rsp_valid && rsp_rdata == held, "R9", "response held", rsp_rdata, held);
    check(rsp_err == e_err, tag, "err flag", {31'b0, rsp_err}, {31'b0, e_err});
    check(rsp_rdata == e_rd, tag, "read data", rsp_rdata, e_rd);
    check(log_n == e_n, tag, "transfer count", log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      check(log_addr[i] == e_addr[i], tag, "transfer addr", {16'b0, log_addr[i]}, {16'b0, e_addr[i]});
      check(log_we[i] == wr, tag, "transfer dir", {31'b0, log_we[i]}, {31'b0, wr});
      if (wr) check(log_data[i] == e_data[i], tag, "transfer data",
                    {16'b0, log_data[i]}, {16'b0, e_data[i]});
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !tgt_req, "R10", "reset state",
          {29'b0, req_ready, rsp_valid, tgt_req}, 32'h4);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b0, 2'b10, 16'hFFFC, '0);          // R1 top-edge word
    run_op(1'b1, 2'b10, 16'h0010, 32'hCAFE_BEEF); // R2
    run_op(1'b0, 2'b11, 16'h0120, '0);          // R3
    run_op(1'b0, 2'b00, 16'hFFFF, '0);          // R4 odd
    run_op(1'b0, 2'b00, 16'h0040, '0);          // R4 even
    run_op(1'b1, 2'b01, 16'h0202, 32'h1234_ABCD); // R5
    run_op(1'b0, 2'b10, 16'h0002, '0);          // R6 misaligned word
    run_op(1'b0, 2'b01, 16'h0003, '0);          // R6 odd halfword
    run_op(1'b1, 2'b00, 16'h0005, 32'hFF);      // R7 byte write
    run_op(1'b1, 2'b11, 16'h0008, 32'h55);      // R7 low-half write
    // random mix; R8 waits are exercised by the model delays
    for (int i = 0; i < 400; i++)
      run_op(1'($urandom), 2'($urandom), 16'($urandom), $urandom);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule